// File: doc/BRIEF.md
# Hop-Count Spoofing Filter

This block screens each arriving packet for a forged source address by checking how far the packet has travelled. It takes the source address and the arrival TTL from an upstream header parser. It works out which common sender default the TTL most likely started from, and subtracts the arrival TTL to get a hop distance.

A small associative table maps each known source address to the distance it was first seen at. A packet whose stored distance differs from the one just computed is reported as spoofed. An address that is not yet in the table is recorded and let through.

A downstream decision stage sees a one-cycle completion strobe and a verdict bit. That stage can abandon the lookup in flight with an abort input, for example when another filter has already condemned the packet. A synchronous clear empties the table in one cycle.

Top module: `ttl_spoof_filter`

## Requirements
- R1: The assumed starting TTL is the smallest value in the set {30, 32, 60, 64, 128, 255} that is not below the arrival TTL. The hop distance is that starting value minus the arrival TTL, as 8 bits. For example, TTL 31 gives 1, TTL 0 gives 30, TTL 129 gives 126 and TTL 255 gives 0.
- R2: When the source address is not in the table, the verdict is legitimate (verdict_legit = 1). The address and its hop distance are stored, so a later packet from that address is compared against the stored distance.
- R3: When the source address is in the table, the verdict is legitimate if the stored distance equals the computed one, and spoofed (verdict_legit = 0) if it does not. A hit never changes the table.
- R4: A header is accepted at a rising edge where in_valid = 1, busy = 0 and clear = 0. busy is high during the following cycle. verdict_done pulses high for exactly one cycle after the next rising edge, and verdict_legit is valid in that same cycle and is held until the next pulse.
- R5: While busy = 1, in_valid and the header inputs are ignored. A header offered then produces no verdict and is not learned.
- R6: When abort = 1 at a rising edge while busy = 1, the lookup in flight is dropped. No verdict_done pulse follows and the table is not written.
- R7: When clear = 1 at a rising edge, every table entry becomes invalid and the replacement position returns to the first slot. A lookup in flight at that edge is dropped without a verdict, and no header is accepted at that edge.
- R8: New addresses fill slots in order. Once all DEPTH slots are used, each new address overwrites the oldest stored one, in round-robin order.
- R9: After reset, busy, verdict_done and verdict_legit are 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Invalidate the whole table and drop any lookup in flight |
| in_valid | input | 1 | Header fields are present |
| in_src_ip | input | 32 | Source address of the packet |
| in_ttl | input | 8 | TTL as seen on arrival |
| abort | input | 1 | Cancel the lookup in flight |
| busy | output | 1 | A lookup is in flight; headers are ignored |
| verdict_done | output | 1 | One-cycle strobe: verdict_legit is valid |
| verdict_legit | output | 1 | 1 = legitimate, 0 = spoofed |

## Verification
The tests learn one address at an arrival TTL and then probe it at TTLs that belong to other starting classes but give the same distance. This separates a correct inference of the starting TTL from one that is off by a class. TTLs that sit exactly on the class edges (30, 31, 32, 60, 64, 128, 129, 255) expose off-by-one errors in the comparison.

A learned address probed with a changed distance separates a hit from a miss. The same probe after an abort, after a header offered while busy, or after a clear shows whether the table was wrongly written or not emptied. Filling every slot and then adding one more address distinguishes a true round-robin replacement from one that overwrites the wrong slot.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int IP_W  = 32;
  localparam int TTL_W = 8;
  localparam int NUM_INIT = 6;
  // Sender default TTLs, ascending; the inference scans this order.
  localparam logic [TTL_W-1:0] INIT_TTL_SET [NUM_INIT] =
    '{8'd30, 8'd32, 8'd60, 8'd64, 8'd128, 8'd255};

  typedef struct packed {
    logic [IP_W-1:0]  ip;
    logic [TTL_W-1:0] hop;
  } probe_t;
endpackage

// File: rtl/tsf_hop_calc.sv
module tsf_hop_calc
  import tsf_pkg::*;
(
  input  logic [TTL_W-1:0] ttl,
  output logic [TTL_W-1:0] hop
);
  logic [TTL_W-1:0] start_ttl;

  // Walk from the largest default down; the last match is the smallest >= ttl.
  always_comb begin
    start_ttl = INIT_TTL_SET[NUM_INIT-1];
    for (int i = NUM_INIT - 1; i >= 0; i--) begin
      if (ttl <= INIT_TTL_SET[i]) start_ttl = INIT_TTL_SET[i];
    end
  end

  assign hop = start_ttl - ttl;
endmodule

// File: rtl/tsf_cam.sv
module tsf_cam #(
  parameter int DEPTH  = 128,
  parameter int KEY_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [KEY_W-1:0]  key,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  input  logic              wr_en,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [KEY_W-1:0]  key_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [DEPTH-1:0]  valid_q;
  logic [PTR_W-1:0]  fill_ptr;
  logic [DEPTH-1:0]  match;

  // One comparator per slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (key_mem[g] == key);
  end

  // Addresses are unique in the table, so an OR of the matching slots is exact.
  always_comb begin
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) hit_data = hit_data | data_mem[i];
    end
  end
  assign hit = |match;

  // Payload storage carries no reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_mem[fill_ptr]  <= wr_key;
      data_mem[fill_ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid_q  <= '0;
      fill_ptr <= '0;
    end else if (wr_en) begin
      valid_q[fill_ptr] <= 1'b1;
      fill_ptr <= (fill_ptr == LAST) ? '0 : fill_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/ttl_spoof_filter.sv
module ttl_spoof_filter
  import tsf_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             in_valid,
  input  logic [IP_W-1:0]  in_src_ip,
  input  logic [TTL_W-1:0] in_ttl,
  input  logic             abort,
  output logic             busy,
  output logic             verdict_done,
  output logic             verdict_legit
);
  logic [TTL_W-1:0] hop_now;
  probe_t           stage_q;
  logic             stage_vld;
  logic             tbl_hit;
  logic [TTL_W-1:0] tbl_hop;
  logic             accept;
  logic             finish;

  tsf_hop_calc u_hop (
    .ttl (in_ttl),
    .hop (hop_now)
  );

  assign accept = in_valid && !stage_vld && !clear;
  assign finish = stage_vld && !abort && !clear;

  always_ff @(posedge clk) begin
    if (accept) begin
      stage_q.ip  <= in_src_ip;
      stage_q.hop <= hop_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_vld     <= 1'b0;
      verdict_done  <= 1'b0;
      verdict_legit <= 1'b0;
    end else begin
      stage_vld    <= accept;
      verdict_done <= finish;
      if (finish) verdict_legit <= !tbl_hit || (tbl_hop == stage_q.hop);
    end
  end

  assign busy = stage_vld;

  tsf_cam #(
    .DEPTH  (DEPTH),
    .KEY_W  (IP_W),
    .DATA_W (TTL_W)
  ) u_cam (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .key      (stage_q.ip),
    .hit      (tbl_hit),
    .hit_data (tbl_hop),
    .wr_en    (finish && !tbl_hit),
    .wr_key   (stage_q.ip),
    .wr_data  (stage_q.hop)
  );
endmodule

// File: rtl/ttl_spoof_filter_chk.sv
module ttl_spoof_filter_chk (
  input logic clk,
  input logic rst,
  input logic clear,
  input logic in_valid,
  input logic abort,
  input logic busy,
  input logic verdict_done
);
  assert_accept_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy && !clear) |=> busy);

  assert_done_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !abort && !clear) |=> verdict_done);

  assert_done_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    verdict_done |=> !verdict_done);

  assert_one_inflight_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  assert_abort_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && abort) |=> !verdict_done);

  assert_clear_drop_R7: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!verdict_done && !busy));

  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (!verdict_done && !busy));
endmodule

bind ttl_spoof_filter ttl_spoof_filter_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .clear        (clear),
  .in_valid     (in_valid),
  .abort        (abort),
  .busy         (busy),
  .verdict_done (verdict_done)
);

// File: tb/ttl_spoof_filter_tb.sv
`timescale 1ns/1ps
module ttl_spoof_filter_tb;
  localparam int DEPTH = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_src_ip = '0;
  logic [7:0]  in_ttl = '0;
  logic        abort = 1'b0;
  logic        busy, verdict_done, verdict_legit;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ttl_spoof_filter #(.DEPTH(DEPTH)) u_dut (
    .clk (clk), .rst (rst), .clear (clear), .in_valid (in_valid),
    .in_src_ip (in_src_ip), .in_ttl (in_ttl), .abort (abort),
    .busy (busy), .verdict_done (verdict_done), .verdict_legit (verdict_legit)
  );

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  // Full lookup; checks busy, the strobe and the verdict.
  task automatic lookup(input logic [31:0] ip, input logic [7:0] ttl,
                        input logic exp_legit, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_src_ip = ip; in_ttl = ttl;
    @(negedge clk);
    in_valid = 1'b0;
    check(busy, 1'b1, {tag, " R4 busy during lookup"});
    check(verdict_done, 1'b0, {tag, " R4 no early strobe"});
    @(negedge clk);
    check(verdict_done, 1'b1, {tag, " R4 strobe"});
    check(verdict_legit, exp_legit, {tag, " verdict"});
    check(busy, 1'b0, {tag, " R4 idle after verdict"});
  endtask

  task automatic pulse_clear();
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
  endtask

  task automatic test_reset_R9();
    check(busy, 1'b0, "R9 busy after reset");
    check(verdict_done, 1'b0, "R9 done after reset");
    check(verdict_legit, 1'b0, "R9 legit after reset");
    lookup(32'h0A00_0001, 8'd40, 1'b1, "R9 empty table gives miss");
  endtask

  task automatic test_hop_R1();
    // Learn distance 1 via TTL 31, probe other classes at distance 1.
    lookup(32'hC0A8_0001, 8'd31, 1'b1, "R1 learn d1");
    lookup(32'hC0A8_0001, 8'd63, 1'b1, "R1 ttl63 d1");
    lookup(32'hC0A8_0001, 8'd127, 1'b1, "R1 ttl127 d1");
    lookup(32'hC0A8_0001, 8'd254, 1'b1, "R1 ttl254 d1");
    lookup(32'hC0A8_0001, 8'd29, 1'b1, "R1 ttl29 d1");
    lookup(32'hC0A8_0001, 8'd30, 1'b0, "R1 ttl30 d0");
    // Distance 30 from TTL 0.
    lookup(32'hC0A8_0002, 8'd0, 1'b1, "R1 learn d30");
    lookup(32'hC0A8_0002, 8'd98, 1'b1, "R1 ttl98 d30");
    lookup(32'hC0A8_0002, 8'd225, 1'b1, "R1 ttl225 d30");
    // Distance 0 at every class edge.
    lookup(32'hC0A8_0003, 8'd60, 1'b1, "R1 learn d0");
    lookup(32'hC0A8_0003, 8'd32, 1'b1, "R1 ttl32 d0");
    lookup(32'hC0A8_0003, 8'd64, 1'b1, "R1 ttl64 d0");
    lookup(32'hC0A8_0003, 8'd128, 1'b1, "R1 ttl128 d0");
    lookup(32'hC0A8_0003, 8'd255, 1'b1, "R1 ttl255 d0");
    lookup(32'hC0A8_0003, 8'd129, 1'b0, "R1 ttl129 d126");
    // Distance 27 across three classes.
    lookup(32'hC0A8_0004, 8'd3, 1'b1, "R1 learn d27");
    lookup(32'hC0A8_0004, 8'd33, 1'b1, "R1 ttl33 d27");
    lookup(32'hC0A8_0004, 8'd101, 1'b1, "R1 ttl101 d27");
    lookup(32'hC0A8_0004, 8'd228, 1'b1, "R1 ttl228 d27");
  endtask

  task automatic test_learn_match_R2_R3();
    lookup(32'h0B0B_0B0B, 8'd50, 1'b1, "R2 first sight legit");
    lookup(32'h0B0B_0B0B, 8'd52, 1'b0, "R2 learned distance used");
    lookup(32'h0B0B_0B0B, 8'd50, 1'b1, "R3 hit equal legit");
    lookup(32'h0B0B_0B0B, 8'd49, 1'b0, "R3 hit unequal spoofed");
    lookup(32'h0B0B_0B0B, 8'd50, 1'b1, "R3 hit left table unchanged");
  endtask

  task automatic test_busy_ignore_R5();
    @(negedge clk);
    in_valid = 1'b1; in_src_ip = 32'h0C00_0001; in_ttl = 8'd100;
    @(negedge clk);
    in_src_ip = 32'h0C00_0002; in_ttl = 8'd10;
    check(busy, 1'b1, "R5 busy with second header offered");
    @(negedge clk);
    in_valid = 1'b0;
    check(verdict_done, 1'b1, "R5 first header verdict");
    @(negedge clk);
    check(verdict_done, 1'b0, "R5 no verdict for ignored header");
    check(busy, 1'b0, "R5 ignored header not in flight");
    lookup(32'h0C00_0002, 8'd11, 1'b1, "R5 ignored header not learned");
  endtask

  task automatic test_abort_R6();
    @(negedge clk);
    in_valid = 1'b1; in_src_ip = 32'h0D00_0001; in_ttl = 8'd70;
    @(negedge clk);
    in_valid = 1'b0; abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(verdict_done, 1'b0, "R6 aborted lookup silent");
    check(busy, 1'b0, "R6 aborted lookup not busy");
    @(negedge clk);
    check(verdict_done, 1'b0, "R6 no late strobe");
    lookup(32'h0D00_0001, 8'd80, 1'b1, "R6 aborted address not learned");
  endtask

  task automatic test_clear_R7();
    lookup(32'h0E00_0001, 8'd20, 1'b1, "R7 learn");
    lookup(32'h0E00_0001, 8'd21, 1'b0, "R7 learned before clear");
    pulse_clear();
    lookup(32'h0E00_0001, 8'd21, 1'b1, "R7 entry gone after clear");
    // Clear with a lookup in flight.
    @(negedge clk);
    in_valid = 1'b1; in_src_ip = 32'h0E00_0002; in_ttl = 8'd20;
    @(negedge clk);
    in_valid = 1'b0; clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check(verdict_done, 1'b0, "R7 in-flight lookup dropped");
    check(busy, 1'b0, "R7 idle after clear");
    lookup(32'h0E00_0002, 8'd22, 1'b1, "R7 dropped lookup not learned");
  endtask

  task automatic test_round_robin_R8();
    pulse_clear();
    for (int i = 0; i < DEPTH; i++) begin
      lookup(32'h2000_0000 + 32'(i), 8'd50, 1'b1, "R8 fill");
    end
    lookup(32'h2000_0000 + 32'(DEPTH), 8'd50, 1'b1, "R8 overflow insert");
    lookup(32'h2000_0001, 8'd40, 1'b0, "R8 second-oldest kept");
    lookup(32'h2000_0000, 8'd40, 1'b1, "R8 oldest replaced");
    lookup(32'h2000_0002, 8'd40, 1'b0, "R8 third-oldest kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    test_reset_R9();
    test_hop_R1();
    test_learn_match_R2_R3();
    test_busy_ignore_R5();
    test_abort_R6();
    test_clear_R7();
    test_round_robin_R8();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule